// File: doc/BRIEF.md
# Iterative AES-128 Decryption Core

This block recovers a 128-bit plaintext block from a 128-bit ciphertext block under a 128-bit cipher key, using the AES-128 inverse cipher. A request is made by raising `start` while the core is idle. On that clock edge the core captures the key and the ciphertext. It first expands the key into all eleven round keys, one 32-bit word per cycle. It then walks through the inverse rounds under a finite state machine and raises `done` with the plaintext on `plainText`.

All round operations are inside the block: key expansion, inverse shift-rows, inverse byte substitution, round-key addition and column unmixing. Both the forward and the inverse substitution bytes are computed by logic, as a multiplicative inverse in GF(2^8) combined with the affine transform, with no stored table. There is only one single-column unmixing unit. The controller therefore spends four sub-states per round, unmixing columns 0, 1, 2 and 3 in turn.

Bytes in every 128-bit value are column-major. The most significant byte is row 0 of column 0, the next byte is row 1 of column 0, and so on. `done` and the result stay put while `start` remains high. Dropping `start` returns the core to idle, where it accepts the next request without a reset.

Top module: `aes_dec_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core returns to idle. After that edge `done` is 0 and `plainText` is all zeros.
- R2: For key 000102030405060708090a0b0c0d0e0f and ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a, the result on `plainText` is 00112233445566778899aabbccddeeff. This uses the column-major byte order, with the most significant byte as row 0 of column 0.
- R3: For any key K and plaintext P, feeding the AES-128 encryption of P under K as ciphertext yields P on `plainText` when `done` is high. This includes the all-zero and all-one key and data corner cases.
- R4: `done` rises exactly 97 clock edges after the edge at which `start` was accepted in idle. The 97 edges are 40 key-word edges, 1 initial key addition, 9 rounds of 6 edges (substitute, add key, four column unmix edges), and a final round of 2 edges.
- R5: While `start` stays high after completion, `done` stays 1 and `plainText` holds its value. This holds even if the key and ciphertext inputs change meanwhile.
- R6: One edge after `start` is seen low with `done` high, `done` returns to 0. A new request can then be started with no reset, and it produces its own correct result.
- R7: The key and ciphertext are sampled only at the accepting edge. Changing them while a decryption is in progress does not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe; accepted in idle, must be dropped after done to return to idle |
| cipherKey | input | 128 | Cipher key, column-major byte order |
| cipherText | input | 128 | Ciphertext block, column-major byte order |
| plainText | output | 128 | Working state; holds the plaintext while done is high |
| done | output | 1 | Completion flag |

## Verification
The core has no tunable parameters. It is built with the package constants, which are four-word blocks and keys, ten rounds and a 44-word key schedule. These values put within reach every key-schedule index from 4 to 43, all ten round-constant values, and every unmix column index. The expected plaintexts come from an encryption model in the bench. That model builds its substitution table by brute-force inverse search, and it is anchored by the standard vector. Random keys and blocks from a fixed seed drive every substitution byte value many times across the runs. The directed cases add all-zero and all-one data, mid-run input changes, a long hold after completion, and back-to-back requests.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;

  localparam int NB          = 4;              // words per block
  localparam int NK          = 4;              // words per key
  localparam int NR          = 10;             // rounds
  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 4 * BYTE_W;
  localparam int BLOCK_W     = NB * WORD_W;
  localparam int TOTAL_WORDS = NB * (NR + 1);
  localparam int WIDX_W      = $clog2(TOTAL_WORDS);
  localparam int RND_W       = $clog2(NR + 1);
  localparam int COL_W       = $clog2(NB);
  // edges from the accepting edge to the edge that raises done
  localparam int LATENCY     = (TOTAL_WORDS - NK) + 1 + (NR - 1) * (2 + NB) + 2;

  typedef struct packed {
    logic              loadIn;
    logic              keyStep;
    logic              addKey;
    logic              shiftSub;
    logic              mixCol;
    logic [WIDX_W-1:0] wordIdx;
    logic [RND_W-1:0]  keyRound;
    logic [COL_W-1:0]  colIdx;
  } ctrl_t;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // x^254 = product of x^(2^k) for k = 1..7; 0 maps to 0
  function automatic logic [7:0] gfInv(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] res;
    sq  = x;
    res = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gfMul(sq, sq);
      res = gfMul(res, sq);
    end
    return res;
  endfunction

  function automatic logic [7:0] affineFwd(input logic [7:0] a);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = a[i] ^ a[(i + 4) % 8] ^ a[(i + 5) % 8] ^ a[(i + 6) % 8] ^ a[(i + 7) % 8];
    return o ^ 8'h63;
  endfunction

  function automatic logic [7:0] affineInv(input logic [7:0] a);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = a[(i + 2) % 8] ^ a[(i + 5) % 8] ^ a[(i + 7) % 8];
    return o ^ 8'h05;
  endfunction

  function automatic logic [7:0] sboxFwd(input logic [7:0] a);
    return affineFwd(gfInv(a));
  endfunction

  function automatic logic [7:0] sboxInv(input logic [7:0] a);
    return gfInv(affineInv(a));
  endfunction

  // round constant for key-schedule group n (1..NR)
  function automatic logic [7:0] rconOf(input logic [RND_W-1:0] n);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 1; k < NR; k++)
      if (k < int'(n)) r = xtime(r);
    return r;
  endfunction

endpackage

// File: rtl/aes_dec_keysched.sv
module aes_dec_keysched
  import aes_dec_pkg::*;
(
  input  logic               clk,
  input  logic               loadKey,
  input  logic               keyStep,
  input  logic [WIDX_W-1:0]  wordIdx,
  input  logic [RND_W-1:0]   keyRound,
  input  logic [BLOCK_W-1:0] cipherKey,
  output logic [BLOCK_W-1:0] roundKey
);

  logic [WORD_W-1:0] wordMem [TOTAL_WORDS];
  logic [WORD_W-1:0] prevWord, backWord, rotWord, subWord, newWord;
  logic [7:0]        rcon;
  logic              groupStart;

  assign prevWord   = wordMem[wordIdx - WIDX_W'(1)];
  assign backWord   = wordMem[wordIdx - WIDX_W'(NK)];
  assign rotWord    = {prevWord[WORD_W-BYTE_W-1:0], prevWord[WORD_W-1 -: BYTE_W]};
  assign groupStart = (wordIdx[COL_W-1:0] == '0);
  assign rcon       = rconOf(RND_W'(wordIdx >> COL_W));

  for (genvar b = 0; b < 4; b++) begin : g_subWord
    assign subWord[b*BYTE_W +: BYTE_W] = sboxFwd(rotWord[b*BYTE_W +: BYTE_W]);
  end

  assign newWord = backWord ^ (groupStart ? (subWord ^ {rcon, 24'h0}) : prevWord);

  always_ff @(posedge clk) begin
    if (loadKey) begin
      for (int k = 0; k < NK; k++)
        wordMem[k] <= cipherKey[BLOCK_W-1-WORD_W*k -: WORD_W];
    end else if (keyStep) begin
      wordMem[wordIdx] <= newWord;
    end
  end

  always_comb begin
    for (int k = 0; k < NB; k++)
      roundKey[BLOCK_W-1-WORD_W*k -: WORD_W] = wordMem[WIDX_W'(int'(keyRound) * NB + k)];
  end

endmodule

// File: rtl/aes_dec_invmixcol.sv
module aes_dec_invmixcol
  import aes_dec_pkg::*;
(
  input  logic [WORD_W-1:0] colIn,
  output logic [WORD_W-1:0] colOut
);

  logic [7:0] a [4];

  for (genvar r = 0; r < 4; r++) begin : g_row
    assign a[r] = colIn[WORD_W-1-BYTE_W*r -: BYTE_W];
    assign colOut[WORD_W-1-BYTE_W*r -: BYTE_W] =
        gfMul(a[r], 8'h0e) ^ gfMul(a[(r + 1) % 4], 8'h0b) ^
        gfMul(a[(r + 2) % 4], 8'h0d) ^ gfMul(a[(r + 3) % 4], 8'h09);
  end

endmodule

// File: rtl/aes_dec_datapath.sv
module aes_dec_datapath
  import aes_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  input  logic [BLOCK_W-1:0] cipherKey,
  input  logic [BLOCK_W-1:0] cipherText,
  output logic [BLOCK_W-1:0] stateOut
);

  logic [BLOCK_W-1:0] stateQ;
  logic [BLOCK_W-1:0] roundKey;
  logic [BLOCK_W-1:0] shiftSubOut;
  logic [WORD_W-1:0]  mixIn, mixOut;

  aes_dec_keysched u_keysched (
    .clk       (clk),
    .loadKey   (ctrl.loadIn),
    .keyStep   (ctrl.keyStep),
    .wordIdx   (ctrl.wordIdx),
    .keyRound  (ctrl.keyRound),
    .cipherKey (cipherKey),
    .roundKey  (roundKey)
  );

  // inverse row shift (row r moves right by r) fused with inverse substitution
  for (genvar c = 0; c < NB; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int SRC = (c - r + NB) % NB;
      assign shiftSubOut[BLOCK_W-1-BYTE_W*(4*c+r) -: BYTE_W] =
          sboxInv(stateQ[BLOCK_W-1-BYTE_W*(4*SRC+r) -: BYTE_W]);
    end
  end

  assign mixIn = stateQ[WORD_W*(NB-1-int'(ctrl.colIdx)) +: WORD_W];

  aes_dec_invmixcol u_invmixcol (
    .colIn  (mixIn),
    .colOut (mixOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= '0;
    end else if (ctrl.loadIn) begin
      stateQ <= cipherText;
    end else if (ctrl.addKey) begin
      stateQ <= stateQ ^ roundKey;
    end else if (ctrl.shiftSub) begin
      stateQ <= shiftSubOut;
    end else if (ctrl.mixCol) begin
      stateQ[WORD_W*(NB-1-int'(ctrl.colIdx)) +: WORD_W] <= mixOut;
    end
  end

  assign stateOut = stateQ;

endmodule

// File: rtl/aes_dec_control.sv
module aes_dec_control
  import aes_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output ctrl_t ctrl,
  output logic  done
);

  typedef enum logic [2:0] {
    S_IDLE, S_KEYEXP, S_INITADD, S_SHIFTSUB, S_ADDKEY, S_MIX, S_FIN
  } fsm_e;

  fsm_e              fsmQ, fsmD;
  logic [WIDX_W-1:0] wordCntQ;
  logic [RND_W-1:0]  roundQ;
  logic [COL_W-1:0]  colQ;

  always_comb begin
    fsmD          = fsmQ;
    ctrl          = '0;
    ctrl.wordIdx  = wordCntQ;
    ctrl.keyRound = roundQ;
    ctrl.colIdx   = colQ;
    unique case (fsmQ)
      S_IDLE: begin
        if (start) begin
          ctrl.loadIn = 1'b1;
          fsmD        = S_KEYEXP;
        end
      end
      S_KEYEXP: begin
        ctrl.keyStep = 1'b1;
        if (wordCntQ == WIDX_W'(TOTAL_WORDS - 1)) fsmD = S_INITADD;
      end
      S_INITADD: begin
        ctrl.addKey   = 1'b1;
        ctrl.keyRound = RND_W'(NR);
        fsmD          = S_SHIFTSUB;
      end
      S_SHIFTSUB: begin
        ctrl.shiftSub = 1'b1;
        fsmD          = S_ADDKEY;
      end
      S_ADDKEY: begin
        ctrl.addKey = 1'b1;
        fsmD        = (roundQ == '0) ? S_FIN : S_MIX;
      end
      S_MIX: begin
        ctrl.mixCol = 1'b1;
        if (colQ == COL_W'(NB - 1)) fsmD = S_SHIFTSUB;
      end
      S_FIN: begin
        if (!start) fsmD = S_IDLE;
      end
      default: fsmD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsmQ     <= S_IDLE;
      wordCntQ <= '0;
      roundQ   <= '0;
      colQ     <= '0;
    end else begin
      fsmQ <= fsmD;
      unique case (fsmQ)
        S_IDLE:    if (start) wordCntQ <= WIDX_W'(NK);
        S_KEYEXP:  wordCntQ <= wordCntQ + WIDX_W'(1);
        S_INITADD: roundQ <= RND_W'(NR - 1);
        S_ADDKEY:  colQ <= '0;
        S_MIX: begin
          colQ <= colQ + COL_W'(1);
          if (colQ == COL_W'(NB - 1)) roundQ <= roundQ - RND_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign done = (fsmQ == S_FIN);

endmodule

// File: rtl/aes_dec_core.sv
module aes_dec_core
  import aes_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BLOCK_W-1:0] cipherKey,
  input  logic [BLOCK_W-1:0] cipherText,
  output logic [BLOCK_W-1:0] plainText,
  output logic               done
);

  ctrl_t ctrl;

  aes_dec_control u_control (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctrl  (ctrl),
    .done  (done)
  );

  aes_dec_datapath u_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .cipherKey  (cipherKey),
    .cipherText (cipherText),
    .stateOut   (plainText)
  );

endmodule

// File: rtl/aes_dec_checker.sv
module aes_dec_checker
  import aes_dec_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               done,
  input logic [BLOCK_W-1:0] plainText
);

  logic     runQ;
  logic [7:0] cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ <= 1'b0;
      cntQ <= '0;
    end else if (!runQ && !done && start) begin
      runQ <= 1'b1;
      cntQ <= '0;
    end else if (runQ) begin
      if (done) runQ <= 1'b0;
      else      cntQ <= cntQ + 8'd1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && plainText == '0));

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (runQ && cntQ == 8'(LATENCY)));

  // R4
  no_early_done_chk: assert property (@(posedge clk) disable iff (rst)
    (runQ && cntQ < 8'(LATENCY)) |-> !done);

  // R5
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (done && $stable(plainText)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

endmodule

bind aes_dec_core aes_dec_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .done      (done),
  .plainText (plainText)
);

// File: tb/aes_dec_core_bench.sv
module aes_dec_core_bench;

  localparam int EXP_LAT = 97;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         startIn = 1'b0;
  logic [127:0] keyIn = '0;
  logic [127:0] ctIn = '0;
  logic [127:0] ptOut;
  logic         doneOut;

  int checkCount = 0;
  int failCount  = 0;
  logic [7:0] sbTab [256];

  always #10 clk = ~clk;

  aes_dec_core u_aes_dec_core (
    .clk        (clk),
    .rst        (rst),
    .start      (startIn),
    .cipherKey  (keyIn),
    .cipherText (ctIn),
    .plainText  (ptOut),
    .done       (doneOut)
  );

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] buildEntry(input logic [7:0] v);
    logic [7:0] inv = '0;
    logic [7:0] o;
    for (int y = 1; y < 256; y++)
      if (v != 0 && bmul(v, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return o ^ 8'h63;
  endfunction

  function automatic logic [127:0] refEncrypt(input logic [127:0] pt, input logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0]  s [4][4];
    logic [7:0]  t [4][4];
    logic [7:0]  rc;
    logic [31:0] tmp;
    logic [127:0] res;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sbTab[tmp[23:16]] ^ rc, sbTab[tmp[15:8]], sbTab[tmp[7:0]], sbTab[tmp[31:24]]};
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[r][c] = pt[127-8*(4*c+r) -: 8] ^ w[c][31-8*r -: 8];
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          t[r][c] = sbTab[s[r][(c+r)%4]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          if (rnd < 10)
            s[r][c] = bmul(t[r][c], 8'h02) ^ bmul(t[(r+1)%4][c], 8'h03) ^
                      t[(r+2)%4][c] ^ t[(r+3)%4][c];
          else
            s[r][c] = t[r][c];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          s[r][c] ^= w[4*rnd+c][31-8*r -: 8];
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        res[127-8*(4*c+r) -: 8] = s[r][c];
    return res;
  endfunction

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  // run one request; start stays high at return (sampled at a negedge)
  task automatic runReq(input logic [127:0] k, input logic [127:0] ct,
                        input bit scramble, output int lat);
    int edges = 0;
    @(negedge clk);
    keyIn   = k;
    ctIn    = ct;
    startIn = 1'b1;
    do begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (scramble && (edges == 3 || edges == 60)) begin
        keyIn = rand128();
        ctIn  = rand128();
      end
    end while (!doneOut && edges < 400);
    lat = edges - 1;
  endtask

  task automatic releaseReq(input string req);
    startIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req, {127'b0, doneOut}, 128'h0);
  endtask

  task automatic decryptCase(input string req, input logic [127:0] k,
                             input logic [127:0] pt, input bit scramble);
    int lat;
    logic [127:0] ct;
    ct = refEncrypt(pt, k);
    runReq(k, ct, scramble, lat);
    check({req, " done"}, {127'b0, doneOut}, 128'h1);
    check(req, ptOut, pt);
    check("R4 latency", 128'(lat), 128'(EXP_LAT));
    releaseReq("R6 done clears");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int lat;
    logic [127:0] held;
    void'($urandom(32'h1F2E3D4C));
    for (int v = 0; v < 256; v++) sbTab[v] = buildEntry(8'(v));

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done after reset", {127'b0, doneOut}, 128'h0);
    check("R1 plaintext after reset", ptOut, 128'h0);
    rst = 1'b0;

    // R2 standard vector, also anchoring the bench model
    check("R2 bench model",
          refEncrypt(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f),
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    runReq(128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0, lat);
    check("R2 standard vector", ptOut, 128'h00112233445566778899aabbccddeeff);
    check("R4 latency", 128'(lat), 128'(EXP_LAT));

    // R5 hold with inputs changing
    held = ptOut;
    for (int i = 0; i < 6; i++) begin
      keyIn = rand128();
      ctIn  = rand128();
      @(posedge clk);
      @(negedge clk);
    end
    check("R5 done held", {127'b0, doneOut}, 128'h1);
    check("R5 plaintext held", ptOut, held);
    releaseReq("R6 done clears");

    // R3 directed corners, back-to-back without reset (R6)
    decryptCase("R3 zero key zero data", 128'h0, 128'h0, 1'b0);
    decryptCase("R3 ones key ones data", {128{1'b1}}, {128{1'b1}}, 1'b0);
    decryptCase("R3 zero key ones data", 128'h0, {128{1'b1}}, 1'b0);
    decryptCase("R6 back-to-back", 128'h000102030405060708090a0b0c0d0e0f, 128'h0, 1'b0);

    // R7 inputs changed mid-run
    decryptCase("R7 mid-run input change", rand128(), rand128(), 1'b1);
    decryptCase("R7 mid-run input change", {128{1'b1}}, rand128(), 1'b1);

    // R3 random vectors
    for (int n = 0; n < 16; n++)
      decryptCase("R3 random", rand128(), rand128(), 1'b0);

    finishRun();
  end

endmodule